// File: doc/BRIEF.md
# Segmented 53x53 Significand Multiplier

This block forms the complete 106-bit unsigned product of two 53-bit significands, each made of the hidden leading bit and the 52-bit fraction of a double-precision value. It sits in the multiply path of a floating-point datapath. Exponent arithmetic, normalization and rounding are handled by the stages around it.

The multiply is not left to a single inferred wide multiplier. Operand A is cut into three fixed slices and operand B into three or four slices, so that every slice pair fits a small hardware multiplier of about 25x18 bits. The design forms ten partial products. Each one is shifted left by the sum of the low bit positions of its two slices. The shifted products are summed serially: every pipeline stage adds one partial product to the running total it received from the previous stage and registers the result. The operands travel down the chain with the running total, and a valid bit travels beside each result. The block therefore accepts one operand pair per cycle and returns each product after a fixed latency.

A synchronous restart flushes every operation in flight. Optional parameters add an input register and choose whether the data registers are reset.

Top module: `segmul53`

## Requirements
- R1: When `prod_vld_o` is high, `prod_o` equals the exact unsigned product of the 53-bit operands, with all 106 bits kept.
- R2: With default parameters (no input register), the product and its `prod_vld_o` pulse appear exactly 10 rising clock edges after the edge that samples `op_vld_i` high. The sampling edge counts as the first of the 10. The input register option adds one edge.
- R3: Operand pairs can be presented on consecutive cycles. Each one produces its own correct result, one per cycle, in the order the pairs were presented.
- R4: While `restart` is high, and during the cycle after it falls, `prod_vld_o` is low. Operations in flight when restart is asserted produce no output. Operands presented during restart produce no output.
- R5: A cycle with `op_vld_i` low produces no `prod_vld_o` pulse, whatever values are on the operand inputs.
- R6: Corner operands give exact results: zero times any operand gives 0; all ones squared gives (2^53-1)^2; the hidden bit alone squared gives 2^104.
- R7: An operand pair whose set bits lie inside one A slice and one B slice gives that slice product placed at the sum of the slice base positions. The A slices are [23:0], [40:24] and [52:41]. The B slices are [16:0], [33:17], [50:34] and [52:51] against A[23:0], and [16:0], [33:17] and [52:34] against the other two A slices.
- R8: Each accumulation stage only adds to the running total, and it forwards its operands unchanged to the next stage one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| restart | input | 1 | Synchronous flush, active high |
| op_vld_i | input | 1 | Operand pair on `op_a_i`/`op_b_i` is valid this cycle |
| op_a_i | input | 53 | Significand A (hidden bit at position 52) |
| op_b_i | input | 53 | Significand B (hidden bit at position 52) |
| prod_vld_o | output | 1 | `prod_o` holds a finished product |
| prod_o | output | 106 | Unsigned product A*B |

## Verification
The bench targets the slice seams. It uses operands confined to a single slice pair, and operands whose carries run across every slice boundary: all ones, and the hidden bit plus the lowest bit. A wrong slice offset or a truncated partial product shows up there as a shifted or missing block of bits. Zero and hidden-bit-only operands expose a stage that drops or doubles a partial product. Back-to-back and gapped streams check the arrival cycle of every result, which would catch a stage that lets the valid bit and the data slip apart. A restart with work in flight catches a valid bit that survives the flush.

// File: rtl/segmul_pkg.sv
package segmul_pkg;

   // Significand and product widths the slicing below is laid out for.
   localparam int unsigned SIG_W   = 53;
   localparam int unsigned FULL_W  = 2 * SIG_W;
   localparam int unsigned NUM_PP  = 10;

   // Slice bounds for each partial product, in accumulation order.
   localparam int unsigned PP_A_LO [NUM_PP] = '{0,  0,  0,  0,  24, 24, 24, 41, 41, 41};
   localparam int unsigned PP_A_HI [NUM_PP] = '{23, 23, 23, 23, 40, 40, 40, 52, 52, 52};
   localparam int unsigned PP_B_LO [NUM_PP] = '{0,  17, 34, 51, 0,  17, 34, 0,  17, 34};
   localparam int unsigned PP_B_HI [NUM_PP] = '{16, 33, 50, 52, 16, 33, 52, 16, 33, 52};

endpackage

// File: rtl/segmul_pp.sv
module segmul_pp #(
   parameter int unsigned AW = 24,
   parameter int unsigned BW = 17
) (
   input  logic [AW-1:0]    a_i,
   input  logic [BW-1:0]    b_i,
   output logic [AW+BW-1:0] p_o
);

   localparam int unsigned PW = AW + BW;

   if (AW > 25 || BW > 19) begin : g_width_err
      $error("segmul_pp: slice %0dx%0d exceeds the small multiplier size", AW, BW);
   end

   always_comb begin
      p_o = PW'(a_i) * PW'(b_i);
   end

endmodule

// File: rtl/segmul_acc_stage.sv
module segmul_acc_stage #(
   parameter int unsigned OP_W       = 53,
   parameter int unsigned PROD_W     = 106,
   parameter int unsigned A_LO       = 0,
   parameter int unsigned A_HI       = 23,
   parameter int unsigned B_LO       = 0,
   parameter int unsigned B_HI       = 16,
   parameter bit          FWD        = 1'b1,
   parameter bit          RESET_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic [OP_W-1:0]   a_i,
   input  logic [OP_W-1:0]   b_i,
   input  logic [PROD_W-1:0] sum_i,
   output logic              vld_o,
   output logic [OP_W-1:0]   a_o,
   output logic [OP_W-1:0]   b_o,
   output logic [PROD_W-1:0] sum_o
);

   localparam int unsigned AW  = A_HI - A_LO + 1;
   localparam int unsigned BW  = B_HI - B_LO + 1;
   localparam int unsigned OFF = A_LO + B_LO;

   if (A_HI < A_LO || B_HI < B_LO || A_HI >= OP_W || B_HI >= OP_W) begin : g_slice_err
      $error("segmul_acc_stage: bad slice bounds");
   end
   if (OFF + AW + BW > PROD_W) begin : g_off_err
      $error("segmul_acc_stage: partial product exceeds product width");
   end

   logic [AW+BW-1:0]  pp;
   logic [PROD_W-1:0] pp_aligned;
   logic [PROD_W-1:0] sum_nxt;

   segmul_pp #(.AW(AW), .BW(BW)) u_pp (
      .a_i (a_i[A_HI:A_LO]),
      .b_i (b_i[B_HI:B_LO]),
      .p_o (pp)
   );

   always_comb begin
      pp_aligned = PROD_W'(pp) << OFF;
      sum_nxt    = sum_i + pp_aligned;
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   if (RESET_DATA) begin : g_sum_rst
      always_ff @(posedge clk) begin
         if (rst)        sum_o <= '0;
         else if (vld_i) sum_o <= sum_nxt;
      end
   end else begin : g_sum_norst
      always_ff @(posedge clk) begin
         if (vld_i) sum_o <= sum_nxt;
      end
   end

   if (FWD) begin : g_fwd
      if (RESET_DATA) begin : g_fwd_rst
         always_ff @(posedge clk) begin
            if (rst) begin
               a_o <= '0;
               b_o <= '0;
            end else if (vld_i) begin
               a_o <= a_i;
               b_o <= b_i;
            end
         end
      end else begin : g_fwd_norst
         always_ff @(posedge clk) begin
            if (vld_i) begin
               a_o <= a_i;
               b_o <= b_i;
            end
         end
      end

      // R8
      fwd_ops_chk: assert property (@(posedge clk) disable iff (rst)
         vld_i |=> (a_o == $past(a_i) && b_o == $past(b_i)));
   end else begin : g_tail
      logic unused_ops;
      assign unused_ops = ^{a_i, b_i};
      assign a_o = '0;
      assign b_o = '0;
   end

   // R2
   vld_track_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (vld_o == $past(vld_i)));

   // R8
   acc_grow_chk: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> (sum_o >= $past(sum_i)));

   // R6
   zero_slice_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && (a_i[A_HI:A_LO] == '0 || b_i[B_HI:B_LO] == '0)) |=> (sum_o == $past(sum_i)));

endmodule

// File: rtl/segmul53.sv
module segmul53 #(
   parameter int unsigned OP_W       = 53,
   parameter bit          IN_REG     = 1'b0,
   parameter bit          RESET_DATA = 1'b0
) (
   input  logic                clk,
   input  logic                restart,
   input  logic                op_vld_i,
   input  logic [OP_W-1:0]     op_a_i,
   input  logic [OP_W-1:0]     op_b_i,
   output logic                prod_vld_o,
   output logic [2*OP_W-1:0]   prod_o
);

   import segmul_pkg::*;

   localparam int unsigned PROD_W  = 2 * OP_W;
   localparam int unsigned STAGES  = NUM_PP;
   localparam int unsigned LATENCY = STAGES + (IN_REG ? 1 : 0);

   if (OP_W != SIG_W) begin : g_width_err
      $error("segmul53: slicing is fixed for %0d-bit significands", SIG_W);
   end
   if (LATENCY < STAGES) begin : g_lat_err
      $error("segmul53: latency below stage count");
   end

   logic              vld_c [STAGES+1];
   logic [OP_W-1:0]   a_c   [STAGES+1];
   logic [OP_W-1:0]   b_c   [STAGES+1];
   logic [PROD_W-1:0] sum_c [STAGES+1];

   if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk) begin
         if (restart) vld_c[0] <= 1'b0;
         else         vld_c[0] <= op_vld_i;
      end
      always_ff @(posedge clk) begin
         if (op_vld_i) begin
            a_c[0] <= op_a_i;
            b_c[0] <= op_b_i;
         end
      end
   end else begin : g_in_wire
      assign vld_c[0] = op_vld_i;
      assign a_c[0]   = op_a_i;
      assign b_c[0]   = op_b_i;
   end

   assign sum_c[0] = '0;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      segmul_acc_stage #(
         .OP_W       (OP_W),
         .PROD_W     (PROD_W),
         .A_LO       (PP_A_LO[k]),
         .A_HI       (PP_A_HI[k]),
         .B_LO       (PP_B_LO[k]),
         .B_HI       (PP_B_HI[k]),
         .FWD        (k < STAGES - 1),
         .RESET_DATA (RESET_DATA)
      ) u_stage (
         .clk   (clk),
         .rst   (restart),
         .vld_i (vld_c[k]),
         .a_i   (a_c[k]),
         .b_i   (b_c[k]),
         .sum_i (sum_c[k]),
         .vld_o (vld_c[k+1]),
         .a_o   (a_c[k+1]),
         .b_o   (b_c[k+1]),
         .sum_o (sum_c[k+1])
      );
   end

   logic unused_tail;
   assign unused_tail = ^{a_c[STAGES], b_c[STAGES]};

   assign prod_vld_o = vld_c[STAGES];
   assign prod_o     = sum_c[STAGES];

   // R4
   restart_flush_chk: assert property (@(posedge clk) disable iff (restart)
      $past(restart) |-> !prod_vld_o);

endmodule

// File: tb/segmul53_tb.sv
`timescale 1ns/1ps
module segmul53_tb_top;

   localparam int LAT  = 10;
   localparam int NVEC = 12;
   localparam logic [52:0] ONES = {53{1'b1}};
   localparam logic [52:0] HID  = 53'h1 << 52;

   localparam logic [52:0] VEC_A [NVEC] = '{
      53'h0, ONES, HID, ONES, HID | 53'h1,
      53'hFFFFFF, 53'h1FFFF << 24, 53'hFFF << 41, 53'hFFFFFF, 53'hFFF << 41,
      53'h1_2345_6789_ABCD, 53'h1 };
   localparam logic [52:0] VEC_B [NVEC] = '{
      ONES, ONES, HID, HID, HID | 53'h1,
      53'h1FFFF << 17, 53'h7FFFF << 34, 53'h1FFFF, 53'h3 << 51, 53'h7FFFF << 34,
      53'h1_DCBA_9876_5432, ONES };

   logic         clk = 1'b0;
   logic         restart = 1'b1;
   logic         op_vld_i = 1'b0;
   logic [52:0]  op_a_i = '0;
   logic [52:0]  op_b_i = '0;
   logic         prod_vld_o;
   logic [105:0] prod_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int issued = 0;
   int received = 0;
   bit done = 1'b0;

   logic [105:0] exp_q [$];
   int           due_q [$];
   string        tag_q [$];

   segmul53 dut_i (
      .clk        (clk),
      .restart    (restart),
      .op_vld_i   (op_vld_i),
      .op_a_i     (op_a_i),
      .op_b_i     (op_b_i),
      .prod_vld_o (prod_vld_o),
      .prod_o     (prod_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [105:0] ref_mul(input logic [52:0] a, input logic [52:0] b);
      logic [105:0] wa, wb;
      wa = {53'd0, a};
      wb = {53'd0, b};
      return wa * wb;
   endfunction

   task automatic check(input bit ok, input string req, input logic [105:0] act, input logic [105:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor runs at the falling edge, before the driver (which waits #1).
   always @(negedge clk) begin
      if (!restart && prod_vld_o) begin
         received++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 output without accepted operands", {105'd0, prod_vld_o}, 106'd0);
         end else begin
            logic [105:0] e;
            int d;
            string t;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            t = tag_q.pop_front();
            check(prod_o === e, {t, " product"}, prod_o, e);
            check(cyc == d, "R2 arrival cycle", 106'(cyc), 106'(d));
         end
      end
   end

   task automatic send(input logic [52:0] a, input logic [52:0] b, input string tag);
      @(negedge clk); #1;
      op_vld_i = 1'b1;
      op_a_i   = a;
      op_b_i   = b;
      exp_q.push_back(ref_mul(a, b));
      due_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
      issued++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         op_vld_i = 1'b0;
         op_a_i   = 53'({$urandom(), $urandom()});
         op_b_i   = 53'({$urandom(), $urandom()});
      end
   endtask

   initial begin
      #500000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R4: reset state
      check(prod_vld_o == 1'b0, "R4 valid low in restart", {105'd0, prod_vld_o}, 106'd0);
      #1 restart = 1'b0;

      // Table of vectors, back to back: R6 corners, R7 slice isolation, R1 general
      for (int i = 0; i < NVEC; i++) begin
         send(VEC_A[i], VEC_B[i], (i < 5) ? "R6" : ((i < 10) ? "R7" : "R1"));
      end
      idle(LAT + 3);
      check(received == issued, "R3 every table op returned", 106'(received), 106'(issued));

      // R3: long back-to-back random stream
      for (int i = 0; i < 200; i++) begin
         logic [52:0] a, b;
         a = 53'({$urandom(), $urandom()});
         b = 53'({$urandom(), $urandom()});
         if (i % 2 == 0) begin
            a[52] = 1'b1;
            b[52] = 1'b1;
         end
         send(a, b, "R3");
      end
      idle(LAT + 3);
      check(received == issued, "R3 back-to-back count", 106'(received), 106'(issued));

      // R5: gapped stream, idle cycles carry random operands
      for (int i = 0; i < 150; i++) begin
         if ($urandom_range(0, 2) == 0) begin
            send(53'({$urandom(), $urandom()}), 53'({$urandom(), $urandom()}), "R1");
         end else begin
            idle(1);
         end
      end
      idle(LAT + 3);
      check(received == issued, "R5 gapped count", 106'(received), 106'(issued));
      check(exp_q.size() == 0, "R5 no missing outputs", 106'(exp_q.size()), 106'd0);

      // R4: restart with work in flight, operands offered during restart
      send(ONES, ONES, "R4");
      send(HID, HID, "R4");
      send(53'h12345, 53'h6789, "R4");
      idle(2);
      @(negedge clk); #1;
      restart  = 1'b1;
      op_vld_i = 1'b1;
      op_a_i   = ONES;
      op_b_i   = ONES;
      exp_q.delete();
      due_q.delete();
      tag_q.delete();
      received = 0;
      issued   = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(prod_vld_o == 1'b0, "R4 valid low during restart", {105'd0, prod_vld_o}, 106'd0);
      end
      #1 restart = 1'b0;
      op_vld_i = 1'b0;
      for (int i = 0; i < LAT + 4; i++) begin
         @(negedge clk);
         check(prod_vld_o == 1'b0, "R4 flushed op resurfaced", {105'd0, prod_vld_o}, 106'd0);
      end

      // R1: pipeline works again after restart
      send(HID | 53'h1, ONES, "R1");
      idle(LAT + 3);
      check(received == 1, "R1 op after restart returned", 106'(received), 106'd1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule